// File: doc/BRIEF.md
# Dual-buffer indirect RAM access port

This block gives a host indirect access to two byte-organized buffer memories, an isochronous buffer and an acknowledged buffer, through one 16-bit data port. The host first loads a byte count. It then issues a single command code that picks the buffer and the direction, and then streams 16-bit words through the data port with no further commands. An internal byte pointer starts at zero and advances by two bytes on every accepted word. When the transfer covers the programmed count, an end-of-transfer event marks the buffer complete and raises a sticky interrupt flag.

The two memories place their bytes in opposite lanes of the 16-bit word. An odd byte count ends with a word that carries only its even-address byte. Data accesses that do not belong to a running transfer are dropped, and any such read returns zero.

Top module: `dual_buf_port`

## Requirements
- R1: Command codes 0x40 (isochronous read), 0xC0 (isochronous write), 0x41 (acknowledged read) and 0xC1 (acknowledged write) start a transfer. Bit 7 of the code selects write and bit 0 selects the acknowledged buffer. Any other code is ignored and leaves status and pointer unchanged.
- R2: A valid command resets the pointer to byte 0, marks the selected buffer active and clears its complete bit. The other buffer's complete bit is kept. At most one buffer is active at a time.
- R3: Each accepted data word moves the pointer forward by two bytes, so consecutive words address consecutive byte pairs starting at byte 0.
- R4: In the isochronous buffer, data bits 15:8 hold the byte at the even address and bits 7:0 hold the byte at the following odd address.
- R5: In the acknowledged buffer, data bits 7:0 hold the byte at the even address and bits 15:8 hold the byte at the odd address.
- R6: When an accepted word brings pointer+2 to or past the byte count, the buffer leaves active, its complete bit sets, and all_eot_o sets. all_eot_o stays set until eot_ack_i is pulsed high.
- R7: With an odd count, the final word writes only its even-address byte, and a read returns zero in the odd-address lane.
- R8: Data accesses with no active transfer, after completion, or in the direction opposite to the command are ignored: nothing is written, the pointer holds, and such a read returns 0x0000.
- R9: A command issued while the count is zero completes at once (complete bit and all_eot_o set). Counts above BUF_BYTES (default 128) are clamped to BUF_BYTES.
- R10: Read data appears on dat_rdata_o in the cycle after the clock edge that samples dat_re_i, and it holds until the next read.
- R11: After reset, status_o, all_eot_o and dat_rdata_o are zero. status_o bit 0 = isochronous active, bit 1 = isochronous complete, bit 2 = acknowledged active, bit 3 = acknowledged complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Load byte count strobe |
| cnt_wdata_i | input | 16 | Byte count value |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command code |
| dat_we_i | input | 1 | Data word write strobe |
| dat_wdata_i | input | 16 | Data word to write |
| dat_re_i | input | 1 | Data word read strobe |
| dat_rdata_o | output | 16 | Data word read result |
| eot_ack_i | input | 1 | Clears the end-of-transfer flag |
| all_eot_o | output | 1 | Sticky end-of-transfer interrupt flag |
| status_o | output | 4 | Per-buffer active and complete bits |

## Verification
The hardest case to reach from the ports is the odd-count final word, together with writes dropped after completion. Both only show as bytes that stayed unchanged in memory. To expose them, the stimulus first fills a region with known words using an even count. It then runs short odd-count or overrun transfers over that region and reads it back with a longer count. The surviving old bytes show the lane order of each buffer and prove that nothing was written past the count.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam logic [7:0] CMD_ISO_RD = 8'h40;
  localparam logic [7:0] CMD_ISO_WR = 8'hC0;
  localparam logic [7:0] CMD_ACK_RD = 8'h41;
  localparam logic [7:0] CMD_ACK_WR = 8'hC1;

  typedef enum logic {
    BUF_ISO = 1'b0,
    BUF_ACK = 1'b1
  } buf_e;

  typedef struct packed {
    logic valid;
    buf_e sel;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/dbp_cmd_dec.sv
module dbp_cmd_dec
  import dbp_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.valid = code_i inside {CMD_ISO_RD, CMD_ISO_WR, CMD_ACK_RD, CMD_ACK_WR};
    cmd_o.sel   = buf_e'(code_i[0]);
    cmd_o.wr    = code_i[7];
  end
endmodule

// File: rtl/dbp_byte_ram.sv
module dbp_byte_ram #(
  parameter int WORDS     = 64,
  parameter int AW        = 6,
  parameter bit HI_IS_ODD = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic          odd_en_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  logic [7:0] even_mem [WORDS];
  logic [7:0] odd_mem  [WORDS];
  logic [7:0] even_w, odd_w;
  logic [7:0] even_q, odd_q;

  generate
    if (HI_IS_ODD) begin : g_lo_even
      assign even_w  = wdata_i[7:0];
      assign odd_w   = wdata_i[15:8];
      assign rdata_o = {odd_q, even_q};
    end else begin : g_hi_even
      assign even_w  = wdata_i[15:8];
      assign odd_w   = wdata_i[7:0];
      assign rdata_o = {even_q, odd_q};
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      even_mem[addr_i] <= even_w;
      if (odd_en_i) odd_mem[addr_i] <= odd_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (re_i) begin
      even_q <= even_mem[addr_i];
      odd_q  <= odd_en_i ? odd_mem[addr_i] : 8'h00;
    end
  end
endmodule

// File: rtl/dbp_xfer_ctrl.sv
module dbp_xfer_ctrl
  import dbp_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int CNT_W     = 8,
  parameter int AW        = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_we_i,
  input  logic [15:0]   cnt_wdata_i,
  input  logic          cmd_we_i,
  input  cmd_t          cmd_i,
  input  logic          dat_we_i,
  input  logic          dat_re_i,
  input  logic          eot_ack_i,
  output logic          acc_o,
  output logic          acc_wr_o,
  output buf_e          sel_o,
  output logic [AW-1:0] word_addr_o,
  output logic          odd_ok_o,
  output logic [3:0]    status_o,
  output logic          all_eot_o
);
  logic [CNT_W-1:0] cnt_q, ptr_q, cnt_d;
  logic [CNT_W:0]   nxt, odd_idx;
  logic [1:0]       active_q, done_q;
  buf_e             sel_q;
  logic             wr_q, all_eot_q;
  logic             cmd_go, busy, last, eot_set;

  assign cmd_go  = cmd_we_i && cmd_i.valid;
  assign busy    = |active_q;
  assign acc_o   = !cmd_go && busy && ((dat_we_i && wr_q) || (dat_re_i && !wr_q));
  assign nxt     = {1'b0, ptr_q} + (CNT_W+1)'(2);
  assign odd_idx = {1'b0, ptr_q} + (CNT_W+1)'(1);
  assign last    = nxt >= {1'b0, cnt_q};
  assign eot_set = (cmd_go && cnt_q == '0) || (acc_o && last);
  assign cnt_d   = (cnt_wdata_i > 16'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : cnt_wdata_i[CNT_W-1:0];

  assign acc_wr_o    = wr_q;
  assign sel_o       = sel_q;
  assign word_addr_o = ptr_q[AW:1];
  assign odd_ok_o    = odd_idx < {1'b0, cnt_q};
  assign status_o    = {done_q[1], active_q[1], done_q[0], active_q[0]};
  assign all_eot_o   = all_eot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ptr_q     <= '0;
      active_q  <= '0;
      done_q    <= '0;
      sel_q     <= BUF_ISO;
      wr_q      <= 1'b0;
      all_eot_q <= 1'b0;
    end else begin
      if (cnt_we_i) cnt_q <= cnt_d;
      if (cmd_go) begin
        sel_q    <= cmd_i.sel;
        wr_q     <= cmd_i.wr;
        ptr_q    <= '0;
        active_q <= '0;
        if (cnt_q == '0) begin
          done_q[cmd_i.sel] <= 1'b1;
        end else begin
          active_q[cmd_i.sel] <= 1'b1;
          done_q[cmd_i.sel]   <= 1'b0;
        end
      end else if (acc_o) begin
        ptr_q <= nxt[CNT_W-1:0];
        if (last) begin
          active_q[sel_q] <= 1'b0;
          done_q[sel_q]   <= 1'b1;
        end
      end
      if (eot_set) all_eot_q <= 1'b1;
      else if (eot_ack_i) all_eot_q <= 1'b0;
    end
  end

  assert_one_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active_q));
  assert_act_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_q[0] && done_q[0]) && !(active_q[1] && done_q[1]));
  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(all_eot_q) |-> $past(eot_ack_i));
  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> ptr_q == $past(ptr_q) + CNT_W'(2));
  assert_cnt_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/dual_buf_port.sv
module dual_buf_port
  import dbp_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cnt_we_i,
  input  logic [15:0] cnt_wdata_i,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_i,
  input  logic        dat_we_i,
  input  logic [15:0] dat_wdata_i,
  input  logic        dat_re_i,
  output logic [15:0] dat_rdata_o,
  input  logic        eot_ack_i,
  output logic        all_eot_o,
  output logic [3:0]  status_o
);
  localparam int WORDS = BUF_BYTES / 2;
  localparam int AW    = $clog2(WORDS);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  cmd_t          cmd;
  logic          acc, acc_wr, odd_ok;
  buf_e          sel, rd_sel_q;
  logic [AW-1:0] word_addr;
  logic          rd_ok_q;
  logic [15:0]   ram_rd [2];

  dbp_cmd_dec u_dec (
    .code_i(cmd_i),
    .cmd_o (cmd)
  );

  dbp_xfer_ctrl #(
    .BUF_BYTES(BUF_BYTES),
    .CNT_W    (CNT_W),
    .AW       (AW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_we_i   (cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i),
    .cmd_we_i   (cmd_we_i),
    .cmd_i      (cmd),
    .dat_we_i   (dat_we_i),
    .dat_re_i   (dat_re_i),
    .eot_ack_i  (eot_ack_i),
    .acc_o      (acc),
    .acc_wr_o   (acc_wr),
    .sel_o      (sel),
    .word_addr_o(word_addr),
    .odd_ok_o   (odd_ok),
    .status_o   (status_o),
    .all_eot_o  (all_eot_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic hit;
    assign hit = (int'(sel) == g);
    dbp_byte_ram #(
      .WORDS    (WORDS),
      .AW       (AW),
      .HI_IS_ODD(g == 1)
    ) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (acc && acc_wr && hit),
      .re_i    (acc && !acc_wr && hit),
      .addr_i  (word_addr),
      .odd_en_i(odd_ok),
      .wdata_i (dat_wdata_i),
      .rdata_o (ram_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ok_q  <= 1'b0;
      rd_sel_q <= BUF_ISO;
    end else if (dat_re_i) begin
      rd_ok_q  <= acc && !acc_wr;
      rd_sel_q <= sel;
    end
  end

  assign dat_rdata_o = !rd_ok_q ? 16'h0000 : (rd_sel_q == BUF_ACK) ? ram_rd[1] : ram_rd[0];

  assert_ign_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_re_i && !status_o[0] && !status_o[2]) |=> dat_rdata_o == 16'h0000);
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_re_i |=> $stable(dat_rdata_o));
endmodule

// File: tb/sim_dual_buf_port.sv
module sim_dual_buf_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_we = 1'b0, cmd_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0, eot_ack = 1'b0;
  logic [15:0] cnt_wdata = '0, dat_wdata = '0;
  logic [7:0]  cmd = '0;
  logic [15:0] dat_rdata;
  logic        all_eot;
  logic [3:0]  status;
  int          checks = 0, failures = 0;

  localparam logic [3:0] ISO_ACT = 4'b0001, ISO_DONE = 4'b0010;
  localparam logic [3:0] ACK_ACT = 4'b0100, ACK_DONE = 4'b1000;

  always #2 clk = ~clk;

  dual_buf_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .dat_we_i(dat_we), .dat_wdata_i(dat_wdata),
    .dat_re_i(dat_re), .dat_rdata_o(dat_rdata), .eot_ack_i(eot_ack),
    .all_eot_o(all_eot), .status_o(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_count(logic [15:0] n);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = n;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic issue(logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_word(logic [15:0] w);
    @(negedge clk); dat_we = 1'b1; dat_wdata = w;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] r);
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0; r = dat_rdata;
  endtask

  task automatic ack_irq();
    @(negedge clk); eot_ack = 1'b1;
    @(negedge clk); eot_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R11 status", 32'(status), 32'h0);
    chk("R11 irq", 32'(all_eot), 32'h0);
    chk("R11 rdata", 32'(dat_rdata), 32'h0);
    rd_word(r);
    chk("R8 read with no command", 32'(r), 32'h0);
  endtask

  task automatic t_iso_stream();
    logic [15:0] w [4] = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718};
    logic [15:0] r;
    set_count(16'd8);
    issue(8'hC0);
    chk("R2 active after command", 32'(status), 32'(ISO_ACT));
    for (int i = 0; i < 3; i++) wr_word(w[i]);
    chk("R6 still active before last", 32'(status), 32'(ISO_ACT));
    chk("R6 no irq before last", 32'(all_eot), 32'h0);
    wr_word(w[3]);
    chk("R6 done after last", 32'(status), 32'(ISO_DONE));
    chk("R6 irq set", 32'(all_eot), 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 irq sticky", 32'(all_eot), 32'h1);
    ack_irq();
    chk("R6 irq cleared by ack", 32'(all_eot), 32'h0);
    issue(8'h40);
    for (int i = 0; i < 4; i++) begin
      rd_word(r);
      chk("R3 sequential readback", 32'(r), 32'(w[i]));
    end
    chk("R6 read done", 32'(status), 32'(ISO_DONE));
    ack_irq();
  endtask

  task automatic t_lanes();
    logic [15:0] r;
    set_count(16'd2); issue(8'hC0); wr_word(16'h1122);
    set_count(16'd1); issue(8'hC0); wr_word(16'h3344);
    set_count(16'd2); issue(8'h40); rd_word(r);
    chk("R4 iso high lane is even byte", 32'(r), 32'h3322);
    set_count(16'd1); issue(8'h40); rd_word(r);
    chk("R7 iso odd count read", 32'(r), 32'h3300);
    set_count(16'd2); issue(8'hC1); wr_word(16'h5566);
    set_count(16'd1); issue(8'hC1); wr_word(16'h7788);
    set_count(16'd2); issue(8'h41); rd_word(r);
    chk("R5 ack low lane is even byte", 32'(r), 32'h5588);
    set_count(16'd1); issue(8'h41); rd_word(r);
    chk("R7 ack odd count read", 32'(r), 32'h0088);
    chk("R6 both complete", 32'(status), 32'(ISO_DONE | ACK_DONE));
    ack_irq();
  endtask

  task automatic t_ignored();
    logic [15:0] r;
    set_count(16'd4); issue(8'hC0);
    wr_word(16'h1111); wr_word(16'h2222);
    wr_word(16'h9999);
    chk("R8 write after completion", 32'(status), 32'(ISO_DONE | ACK_DONE));
    rd_word(r);
    chk("R8 read after completion", 32'(r), 32'h0);
    set_count(16'd6); issue(8'h40);
    chk("R2 other done kept", 32'(status), 32'(ISO_ACT | ACK_DONE));
    wr_word(16'h7777);
    chk("R8 wrong direction keeps active", 32'(status), 32'(ISO_ACT | ACK_DONE));
    rd_word(r);
    chk("R8 pointer held on wrong direction", 32'(r), 32'h1111);
    rd_word(r);
    chk("R3 second word", 32'(r), 32'h2222);
    rd_word(r);
    chk("R8 overrun write not stored", 32'(r), 32'hE5F6);
    chk("R6 done", 32'(status), 32'(ISO_DONE | ACK_DONE));
    ack_irq();
  endtask

  task automatic t_bad_cmd();
    logic [15:0] r;
    set_count(16'd4); issue(8'h40);
    rd_word(r);
    chk("R1 first word", 32'(r), 32'h1111);
    issue(8'h80);
    chk("R1 invalid code keeps status", 32'(status), 32'(ISO_ACT | ACK_DONE));
    rd_word(r);
    chk("R1 invalid code keeps pointer", 32'(r), 32'h2222);
    issue(8'h42);
    chk("R1 invalid code after done", 32'(status), 32'(ISO_DONE | ACK_DONE));
    ack_irq();
  endtask

  task automatic t_zero_clamp();
    set_count(16'd0); issue(8'hC1);
    chk("R9 zero count completes", 32'(status), 32'(ISO_DONE | ACK_DONE));
    chk("R9 zero count irq", 32'(all_eot), 32'h1);
    ack_irq();
    set_count(16'hFFFF); issue(8'hC1);
    chk("R9 clamped transfer active", 32'(status), 32'(ISO_DONE | ACK_ACT));
    for (int i = 0; i < 63; i++) wr_word(16'hA500 + 16'(i));
    chk("R9 active before clamp limit", 32'(status), 32'(ISO_DONE | ACK_ACT));
    wr_word(16'hA53F);
    chk("R9 done at clamp limit", 32'(status), 32'(ISO_DONE | ACK_DONE));
    ack_irq();
  endtask

  task automatic t_hold();
    logic [15:0] r;
    set_count(16'd2); issue(8'h41);
    @(negedge clk); dat_re = 1'b1;
    @(posedge clk); #1 dat_re = 1'b0;
    @(negedge clk); r = dat_rdata;
    chk("R10 data after one edge", 32'(r), 32'hA500);
    repeat (5) @(negedge clk);
    chk("R10 data held", 32'(dat_rdata), 32'hA500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_iso_stream();
    t_lanes();
    t_ignored();
    t_bad_cmd();
    t_zero_clamp();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule